// File: doc/BRIEF.md
# DDS Phase Word Generator

This block forms the phase word of a direct digital synthesizer. A 32-bit accumulator grows by a frequency tuning word on every clock. The top 12 accumulator bits, plus a 12-bit phase offset, give a 12-bit phase word for a downstream sine table. One select bit chooses one of two tuning words. A two-bit select chooses one of four phase offsets. These selects give frequency-shift and phase-shift keying without rewriting any register.

The selects are sampled on the rising clock edge. All paths to the output are padded to one fixed latency. A new frequency, a new offset, or a change of select therefore reaches the output in the same cycle. The tuning words and offsets come in as ports, and reset leaves them untouched. Reset clears the accumulator and the pipeline. A valid flag rises once the pipeline holds data that was sampled after reset.

Top module: `dds_phase_core`

## Requirements
- R1: The accumulator is 32 bits wide. It adds the selected tuning word on every clock and wraps modulo 2^32 without saturation.
- R2: When `fsel_i` is 0, tuning word `ftw0_i` is used. When it is 1, `ftw1_i` is used.
- R3: `psel_i` is an index from 0 to 3 that picks `pofs0_i` .. `pofs3_i`.
- R4: `phase_o` equals accumulator bits [31:20] plus the selected offset, modulo 4096.
- R5: Inputs sampled at clock edge n reach `phase_o` after edge n+5, a six-cycle latency. This holds for select changes and for new register values alike. The output after edge n+5 includes the tuning word sampled at edge n.
- R6: An active-low asynchronous reset clears the accumulator and the pipeline. While reset is held, `phase_o` is 0 and `valid_o` is 0.
- R7: `valid_o` goes to 1 after the sixth rising edge following reset release. It stays at 1 until the next reset.
- R8: Selects, tuning words and offsets may change on every clock, and each cycle's values are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_i | input | 1 | Tuning word select |
| psel_i | input | 2 | Phase offset select |
| ftw0_i | input | 32 | Tuning word 0 |
| ftw1_i | input | 32 | Tuning word 1 |
| pofs0_i | input | 12 | Phase offset 0 |
| pofs1_i | input | 12 | Phase offset 1 |
| pofs2_i | input | 12 | Phase offset 2 |
| pofs3_i | input | 12 | Phase offset 3 |
| phase_o | output | 12 | Output phase word |
| valid_o | output | 1 | Pipeline filled since reset |

## Verification
Several input patterns are compared every cycle against a model of the cumulative sum:

- A steady tuning word of 2^20 advances the phase by exactly one step per cycle. A mismatch here shows an off-by-one latency.
- A word of 2^31 toggles bit 11 on alternate cycles. This exposes wrap or carry faults.
- Toggling `fsel_i` with very different words shows both which word was chosen and in which cycle it took effect.
- Stepping `psel_i` through all four offsets with a zero tuning word isolates the offset path from the accumulator.
- Changing every input every cycle, from a pseudo-random sequence, separates a correctly aligned pipeline from one whose offset and accumulator paths are skewed.

A reset in the middle of a run checks that the output and the valid flag restart cleanly.

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int LAT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsel_i,
  input  logic [1:0]       psel_i,
  input  logic [ACC_W-1:0] ftw0_i,
  input  logic [ACC_W-1:0] ftw1_i,
  input  logic [PH_W-1:0]  pofs0_i,
  input  logic [PH_W-1:0]  pofs1_i,
  input  logic [PH_W-1:0]  pofs2_i,
  input  logic [PH_W-1:0]  pofs3_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             valid_o
);
  localparam int TAIL = LAT - 3;

  logic [ACC_W-1:0] ftw_q, acc_q;
  logic [PH_W-1:0]  pofs_q, pofs_d;
  logic [PH_W-1:0]  ph_pipe [TAIL+1];
  logic [LAT-1:0]   vld_sr;
  logic [PH_W-1:0]  pofs_sel;

  always_comb begin
    case (psel_i)
      2'd0:    pofs_sel = pofs0_i;
      2'd1:    pofs_sel = pofs1_i;
      2'd2:    pofs_sel = pofs2_i;
      default: pofs_sel = pofs3_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q  <= '0;
      pofs_q <= '0;
      acc_q  <= '0;
      pofs_d <= '0;
      vld_sr <= '0;
      for (int i = 0; i <= TAIL; i++) ph_pipe[i] <= '0;
    end else begin
      ftw_q      <= fsel_i ? ftw1_i : ftw0_i;
      pofs_q     <= pofs_sel;
      acc_q      <= acc_q + ftw_q;
      pofs_d     <= pofs_q;
      ph_pipe[0] <= acc_q[ACC_W-1 -: PH_W] + pofs_d;
      for (int i = 1; i <= TAIL; i++) ph_pipe[i] <= ph_pipe[i-1];
      vld_sr     <= {vld_sr[LAT-2:0], 1'b1};
    end
  end

  assign phase_o = ph_pipe[TAIL];
  assign valid_o = vld_sr[LAT-1];

  a_r2_freq_pick: assert property (@(posedge clk) disable iff (!rst_n)
    vld_sr[0] |-> ftw_q == ($past(fsel_i) ? $past(ftw1_i) : $past(ftw0_i)));

  a_r3_offset_pick: assert property (@(posedge clk) disable iff (!rst_n)
    vld_sr[0] |-> pofs_q == (($past(psel_i) == 2'd0) ? $past(pofs0_i) :
                             ($past(psel_i) == 2'd1) ? $past(pofs1_i) :
                             ($past(psel_i) == 2'd2) ? $past(pofs2_i) : $past(pofs3_i)));

  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

  a_r1_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_sr[1] && ftw_q == '0) |=> $stable(acc_q));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r6_reset_clear: assert (acc_q == '0 && !valid_o && phase_o == '0);
    end
  end
endmodule

// File: tb/dds_phase_core_tb.sv
module dds_phase_core_tb;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        fsel = 0;
  logic [1:0]  psel = 0;
  logic [31:0] ftw0 = 0, ftw1 = 0;
  logic [11:0] po0 = 0, po1 = 0, po2 = 0, po3 = 0;
  logic [11:0] phase;
  logic        valid;

  int checks = 0, errors = 0;
  string tag = "R6";

  dds_phase_core u_dut (
    .clk(clk), .rst_n(rst_n), .fsel_i(fsel), .psel_i(psel),
    .ftw0_i(ftw0), .ftw1_i(ftw1),
    .pofs0_i(po0), .pofs1_i(po1), .pofs2_i(po2), .pofs3_i(po3),
    .phase_o(phase), .valid_o(valid)
  );

  always #(CLK_P/2) clk = ~clk;

  // Reference: output after edge e = cumsum(words up to edge e-5)[31:20] + offset(e-5)
  int          ecnt = 0;
  logic [31:0] cum = 0;
  logic [31:0] h_cum [8];
  logic [11:0] h_po  [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      ecnt = 0;
      cum  = 0;
    end else begin
      logic [11:0] p;
      cum = cum + (fsel ? ftw1 : ftw0);
      case (psel)
        2'd0: p = po0; 2'd1: p = po1; 2'd2: p = po2; default: p = po3;
      endcase
      h_cum[ecnt % 8] = cum;
      h_po[ecnt % 8]  = p;
      ecnt++;
    end
  end

  task automatic check(input string t, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at time %0t", t, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [11:0] e_ph;
    logic        e_v;
    @(negedge clk);
    if (!rst_n || ecnt < 6) begin
      e_ph = 0;
      e_v  = 0;
    end else begin
      e_ph = h_cum[(ecnt - 6) % 8][31:20] + h_po[(ecnt - 6) % 8];
      e_v  = 1;
    end
    check({tag, " phase"}, phase, e_ph);
    check({tag, " valid"}, {11'd0, valid}, {11'd0, e_v});
  endtask

  task automatic do_reset();
    tag = "R6";
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  task automatic t_valid_timing();  // R7
    tag = "R7";
    ftw0 = 32'h0010_0000; fsel = 0; psel = 0; po0 = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R7 valid low while filling", {11'd0, valid}, 12'd0);
    end
    tick();
    check("R7 valid after sixth edge", {11'd0, valid}, 12'd1);
  endtask

  task automatic t_steady_ramp();  // R4, R5
    tag = "R4";
    repeat (20) tick();
  endtask

  task automatic t_wrap();  // R1
    tag = "R1";
    ftw0 = 32'h8000_0000;
    repeat (12) tick();
    ftw0 = 32'hFFFF_FFFF;
    repeat (12) tick();
  endtask

  task automatic t_fsk();  // R2, R5
    tag = "R2";
    ftw0 = 32'h0010_0000; ftw1 = 32'h0700_0000;
    for (int i = 0; i < 30; i++) begin
      fsel = (i % 3 == 0);
      tick();
    end
    fsel = 0;
  endtask

  task automatic t_psk();  // R3
    tag = "R3";
    ftw0 = 0; ftw1 = 0;
    po0 = 12'h000; po1 = 12'h400; po2 = 12'h800; po3 = 12'hC01;
    for (int i = 0; i < 24; i++) begin
      psel = 2'(i / 2);
      tick();
    end
    repeat (6) tick();
  endtask

  task automatic t_latency();  // R5: register rewrite lands exactly 6 edges later
    tag = "R5";
    ftw0 = 0; psel = 2'd1; po1 = 12'h123;
    repeat (8) tick();
    po1 = 12'h456;
    for (int i = 0; i < 8; i++) tick();
  endtask

  task automatic t_every_cycle();  // R8
    logic [31:0] lfsr = 32'hACE1_1234;
    tag = "R8";
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      fsel = lfsr[3];
      psel = lfsr[7:6];
      ftw0 = lfsr * 32'd3;
      ftw1 = ~lfsr;
      po0  = lfsr[11:0];
      po2  = lfsr[23:12];
      tick();
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_valid_timing();
    t_steady_ramp();
    t_wrap();
    t_fsk();
    t_psk();
    t_latency();
    t_every_cycle();
    do_reset();           // R6 mid-run reset
    t_valid_timing();
    t_steady_ramp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule